// File: doc/BRIEF.md
# Shared-Memory Mailbox Register Bridge

This block gives a host indirect access to a peripheral's internal control registers through a 64-byte shared memory. The host has just two locations. Location 0 is a pointer that picks one shared byte, and location 1 reads or writes the byte that the pointer selects. To change a peripheral register, the host places the register number and a value in fixed shared bytes, then writes a request code into the command byte. To read a register, it places the register number, writes the read code, and waits for the command byte to return to zero. The value byte then holds the register contents.

A bridge engine on the peripheral side watches the command byte. When the byte is non-zero it takes the request, carries out the register access, and clears the command byte to zero. Clearing the byte is the acknowledge. The shared memory also carries a live copy of two status inputs in fixed bytes. A byte stream from the peripheral's receive path is written into a 32-byte ring in the upper half of the memory. The internal register file is modelled and is also driven out as a flat bus.

Host requests use a valid/ready channel and read data returns on a valid/ready response channel. A request is taken when `host_valid` and `host_ready` are both high. `host_ready` is low only while a read response is waiting and `rsp_ready` is low. The receive byte stream is never back-pressured: `rx_ready` is always high.

Top module: `shm_mailbox_bridge`

## Requirements
- R1: After reset every shared byte, every peripheral register and the host pointer read as 0. `rsp_valid` is 0 and `host_ready` is 1.
- R2: A host write with `host_sel`=0 loads the pointer with `host_wdata[5:0]`. A host read with `host_sel`=0 returns the pointer zero-extended to 8 bits.
- R3: A host write with `host_sel`=1 stores `host_wdata` into the shared byte the pointer selects. A host read with `host_sel`=1 returns that byte. Read data appears with `rsp_valid` one cycle after the request is taken and is held stable until `rsp_ready`. `host_ready` is low exactly while a response is waiting and `rsp_ready` is low.
- R4: Command byte 0x1A, register number byte 0x1B, value byte 0x1C. Command code 1 (write) copies byte 0x1C into register [byte 0x1B]. The command byte returns to 0 within three cycles of the bridge seeing it, and that happens in the cycle after the register write.
- R5: Command code 2 (read) stores register [byte 0x1B] into byte 0x1C one cycle before the command byte returns to 0.
- R6: A register number of NREGS or above (16 by default) changes no register. A read request with such a number returns 0x00 in byte 0x1C. Both kinds of request are still acknowledged.
- R7: Any command code other than 0, 1 or 2 is cleared to 0. No register and no other shared byte changes.
- R8: Byte 0x1E follows `irq_id` and byte 0x1F follows `rx_status`, each one cycle late.
- R9: Each cycle with `rx_valid` high writes `rx_data` to byte 0x20+k, where k counts received bytes modulo 32 starting at 0. `rx_ready` is always 1.
- R10: When the host and the bridge write the same shared byte in the same cycle, the host value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Host request accepted when high together with valid |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = pointer location, 1 = data location |
| host_wdata | input | 8 | Host write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host can take the read response |
| rsp_data | output | 8 | Read response data |
| irq_id | input | 8 | Interrupt identification, mirrored to byte 0x1E |
| rx_status | input | 8 | Receive FIFO status, mirrored to byte 0x1F |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Always 1 |
| rx_data | input | 8 | Receive byte |
| periph_regs | output | NREGS*8 | Register file, register n at bits [8n+7:8n] |

## Verification
The hardest case to reach from the ports is a host write landing on the value byte in the same edge in which the bridge writes its read result there. The host can only touch one byte per request, and its pointer must first be moved away from the command byte. The stimulus issues three accepted requests on back-to-back cycles: the read command, a pointer move to 0x1C, and the colliding data write. That sequence times the third write onto the bridge's execute cycle. A cycle-level behavioural model then confirms the collision outcome and the ring wrap after 33 received bytes.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int SHM_AW    = 6;
  localparam int SHM_DEPTH = 1 << SHM_AW;
  localparam int FIFO_SLOTS = SHM_DEPTH / 2;

  localparam logic [SHM_AW-1:0] OFF_MODE = 6'h1A;
  localparam logic [SHM_AW-1:0] OFF_RIDX = 6'h1B;
  localparam logic [SHM_AW-1:0] OFF_RVAL = 6'h1C;
  localparam logic [SHM_AW-1:0] OFF_IRQ  = 6'h1E;
  localparam logic [SHM_AW-1:0] OFF_RXS  = 6'h1F;
  localparam logic [SHM_AW-1:0] OFF_FIFO = 6'h20;

  localparam logic [7:0] CMD_IDLE  = 8'h00;
  localparam logic [7:0] CMD_WRITE = 8'h01;
  localparam logic [7:0] CMD_READ  = 8'h02;

  typedef enum logic [1:0] {BR_POLL, BR_EXEC, BR_ACK} br_state_t;

  typedef struct packed {
    logic              we;
    logic [SHM_AW-1:0] addr;
    logic [7:0]        data;
  } shm_wr_t;
endpackage

// File: rtl/mbox_host_port.sv
module mbox_host_port
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_we,
  input  logic              host_sel,
  input  logic [7:0]        host_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  input  logic [7:0]        shm_rdata,
  output logic [SHM_AW-1:0] cur_idx,
  output shm_wr_t           host_wr
);
  logic accept;
  logic [SHM_AW-1:0] idx_q;

  assign host_ready = ~rsp_valid | rsp_ready;
  assign accept     = host_valid & host_ready;
  assign cur_idx    = idx_q;

  always_comb begin
    host_wr.we   = accept & host_we & host_sel;
    host_wr.addr = idx_q;
    host_wr.data = host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (accept && host_we && !host_sel) begin
      idx_q <= host_wdata[SHM_AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && !host_we) begin
      rsp_valid <= 1'b1;
      rsp_data  <= host_sel ? shm_rdata : {{(8-SHM_AW){1'b0}}, idx_q};
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_shm.sv
module mbox_shm
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  shm_wr_t           host_wr,
  input  shm_wr_t           fsm_wr,
  input  shm_wr_t           rx_wr,
  input  logic [7:0]        irq_byte,
  input  logic [7:0]        rxs_byte,
  input  logic [SHM_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [7:0]        mode_byte,
  output logic [7:0]        ridx_byte,
  output logic [7:0]        rval_byte
);
  logic [7:0] mem [SHM_DEPTH];

  // Priority per byte: host, bridge engine, receive ring, status mirror.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SHM_DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < SHM_DEPTH; i++) begin
        if (host_wr.we && host_wr.addr == SHM_AW'(i))
          mem[i] <= host_wr.data;
        else if (fsm_wr.we && fsm_wr.addr == SHM_AW'(i))
          mem[i] <= fsm_wr.data;
        else if (rx_wr.we && rx_wr.addr == SHM_AW'(i))
          mem[i] <= rx_wr.data;
        else if (SHM_AW'(i) == OFF_IRQ)
          mem[i] <= irq_byte;
        else if (SHM_AW'(i) == OFF_RXS)
          mem[i] <= rxs_byte;
      end
    end
  end

  assign rd_data   = mem[rd_addr];
  assign mode_byte = mem[OFF_MODE];
  assign ridx_byte = mem[OFF_RIDX];
  assign rval_byte = mem[OFF_RVAL];
endmodule

// File: rtl/mbox_rx_copy.sv
module mbox_rx_copy
  import mbox_pkg::*;
#(
  parameter int SLOTS = FIFO_SLOTS
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  output shm_wr_t    rx_wr
);
  localparam int PW = $clog2(SLOTS);
  logic [PW-1:0] ptr_q;

  assign rx_ready = 1'b1;

  always_comb begin
    rx_wr.we   = rx_valid;
    rx_wr.addr = OFF_FIFO + SHM_AW'(ptr_q);
    rx_wr.data = rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (rx_valid) begin
      ptr_q <= (int'(ptr_q) == SLOTS - 1) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/mbox_regfile.sv
module mbox_regfile #(
  parameter int NREGS = 16,
  localparam int RIW  = $clog2(NREGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [RIW-1:0]     idx,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  output logic [NREGS*8-1:0] regs_flat
);
  logic [7:0] regs [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we) begin
      regs[idx] <= wdata;
    end
  end

  assign rdata = regs[idx];

  for (genvar g = 0; g < NREGS; g++) begin : g_flat
    assign regs_flat[g*8 +: 8] = regs[g];
  end
endmodule

// File: rtl/mbox_bridge_fsm.sv
module mbox_bridge_fsm
  import mbox_pkg::*;
#(
  parameter int NREGS = 16,
  localparam int RIW  = $clog2(NREGS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     mode_byte,
  input  logic [7:0]     ridx_byte,
  input  logic [7:0]     rval_byte,
  input  logic [7:0]     reg_rdata,
  output logic           reg_we,
  output logic [RIW-1:0] reg_idx,
  output logic [7:0]     reg_wdata,
  output shm_wr_t        fsm_wr
);
  br_state_t  state_q;
  logic [7:0] cmd_q, num_q, val_q;
  logic       in_range;

  assign in_range  = (32'(num_q) < 32'(NREGS));
  assign reg_idx   = num_q[RIW-1:0];
  assign reg_wdata = val_q;
  assign reg_we    = (state_q == BR_EXEC) && (cmd_q == CMD_WRITE) && in_range;

  always_comb begin
    fsm_wr.we   = 1'b0;
    fsm_wr.addr = OFF_RVAL;
    fsm_wr.data = '0;
    if (state_q == BR_EXEC && cmd_q == CMD_READ) begin
      fsm_wr.we   = 1'b1;
      fsm_wr.data = in_range ? reg_rdata : 8'h00;
    end else if (state_q == BR_ACK) begin
      fsm_wr.we   = 1'b1;
      fsm_wr.addr = OFF_MODE;
      fsm_wr.data = CMD_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BR_POLL;
      cmd_q   <= '0;
      num_q   <= '0;
      val_q   <= '0;
    end else begin
      unique case (state_q)
        BR_POLL: if (mode_byte != CMD_IDLE) begin
          cmd_q   <= mode_byte;
          num_q   <= ridx_byte;
          val_q   <= rval_byte;
          state_q <= BR_EXEC;
        end
        BR_EXEC: state_q <= BR_ACK;
        default: state_q <= BR_POLL;
      endcase
    end
  end
endmodule

// File: rtl/shm_mailbox_bridge.sv
module shm_mailbox_bridge
  import mbox_pkg::*;
#(
  parameter int NREGS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  output logic               host_ready,
  input  logic               host_we,
  input  logic               host_sel,
  input  logic [7:0]         host_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [7:0]         rsp_data,
  input  logic [7:0]         irq_id,
  input  logic [7:0]         rx_status,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic [7:0]         rx_data,
  output logic [NREGS*8-1:0] periph_regs
);
  localparam int RIW = $clog2(NREGS);

  shm_wr_t           host_wr, fsm_wr, rx_wr;
  logic [SHM_AW-1:0] cur_idx;
  logic [7:0]        shm_rdata, mode_byte, ridx_byte, rval_byte;
  logic              reg_we;
  logic [RIW-1:0]    reg_idx;
  logic [7:0]        reg_wdata, reg_rdata;

  mbox_host_port u_host (
    .clk, .rst_n, .host_valid, .host_ready, .host_we, .host_sel, .host_wdata,
    .rsp_valid, .rsp_ready, .rsp_data, .shm_rdata, .cur_idx, .host_wr
  );

  mbox_shm u_shm (
    .clk, .rst_n, .host_wr, .fsm_wr, .rx_wr,
    .irq_byte(irq_id), .rxs_byte(rx_status),
    .rd_addr(cur_idx), .rd_data(shm_rdata),
    .mode_byte, .ridx_byte, .rval_byte
  );

  mbox_rx_copy #(.SLOTS(FIFO_SLOTS)) u_rx (
    .clk, .rst_n, .rx_valid, .rx_ready, .rx_data, .rx_wr
  );

  mbox_bridge_fsm #(.NREGS(NREGS)) u_fsm (
    .clk, .rst_n, .mode_byte, .ridx_byte, .rval_byte, .reg_rdata,
    .reg_we, .reg_idx, .reg_wdata, .fsm_wr
  );

  mbox_regfile #(.NREGS(NREGS)) u_regs (
    .clk, .rst_n, .we(reg_we), .idx(reg_idx), .wdata(reg_wdata),
    .rdata(reg_rdata), .regs_flat(periph_regs)
  );
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker
  import mbox_pkg::*;
#(
  parameter int NREGS = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_valid,
  input logic               host_ready,
  input logic               host_we,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [7:0]         rsp_data,
  input logic               reg_we,
  input logic               fsm_we,
  input logic [SHM_AW-1:0]  fsm_addr,
  input logic [7:0]         fsm_data,
  input logic [NREGS*8-1:0] periph_regs
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R3
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && host_ready && !host_we |=> rsp_valid); // R3
  AST_WRITE_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> fsm_we && fsm_addr == OFF_MODE && fsm_data == CMD_IDLE); // R4
  AST_VALUE_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_we && fsm_addr == OFF_RVAL |=> fsm_we && fsm_addr == OFF_MODE); // R5
  AST_REGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(periph_regs)); // R7
endmodule

bind shm_mailbox_bridge mbox_checker #(.NREGS(NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
  .host_we(host_we), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .reg_we(reg_we), .fsm_we(fsm_wr.we),
  .fsm_addr(fsm_wr.addr), .fsm_data(fsm_wr.data), .periph_regs(periph_regs)
);

// File: tb/sim_shm_mailbox_bridge.sv
`timescale 1ns/1ps
module sim_shm_mailbox_bridge;
  localparam int NR = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_valid = 0, host_we = 0, host_sel = 0, rsp_ready = 1;
  logic [7:0] host_wdata = '0, irq_id = '0, rx_status = '0, rx_data = '0;
  logic rx_valid = 0;
  logic host_ready, rsp_valid, rx_ready;
  logic [7:0] rsp_data;
  logic [NR*8-1:0] periph_regs;

  always #2 clk = ~clk;

  shm_mailbox_bridge #(.NREGS(NR)) u0 (
    .clk, .rst_n, .host_valid, .host_ready, .host_we, .host_sel, .host_wdata,
    .rsp_valid, .rsp_ready, .rsp_data, .irq_id, .rx_status, .rx_valid,
    .rx_ready, .rx_data, .periph_regs
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // Behavioural reference model
  logic [7:0] m_mem [64];
  logic [7:0] m_regs [NR];
  int m_phase, m_ptr;
  logic [7:0] m_cmd, m_num, m_val, m_rspd;
  logic [5:0] m_idx;
  logic m_rspv;

  always @(posedge clk or negedge rst_n) begin
    logic [7:0] nm [64];
    logic acc;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) m_mem[i] = 0;
      for (int i = 0; i < NR; i++) m_regs[i] = 0;
      m_phase = 0; m_ptr = 0; m_cmd = 0; m_num = 0; m_val = 0;
      m_idx = 0; m_rspv = 0; m_rspd = 0;
    end else begin
      nm = m_mem;
      acc = host_valid && (!m_rspv || rsp_ready);
      nm[30] = irq_id;
      nm[31] = rx_status;
      if (rx_valid) begin
        nm[32 + m_ptr] = rx_data;
        m_ptr = (m_ptr + 1) % 32;
      end
      case (m_phase)
        0: if (m_mem[26] != 0) begin
             m_cmd = m_mem[26]; m_num = m_mem[27]; m_val = m_mem[28]; m_phase = 1;
           end
        1: begin
             if (m_cmd == 1 && m_num < NR) m_regs[m_num] = m_val;
             if (m_cmd == 2) nm[28] = (m_num < NR) ? m_regs[m_num] : 8'h00;
             m_phase = 2;
           end
        default: begin nm[26] = 0; m_phase = 0; end
      endcase
      if (acc) begin
        if (host_we) begin
          if (host_sel) nm[m_idx] = host_wdata;
          else m_idx = host_wdata[5:0];
          m_rspv = 0;
        end else begin
          m_rspv = 1;
          m_rspd = host_sel ? m_mem[m_idx] : {2'b00, m_idx};
        end
      end else if (m_rspv && rsp_ready) begin
        m_rspv = 0;
      end
      m_mem = nm;
    end
  end

  // Per-cycle comparison against the model, away from the edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit bad;
      bad = 0;
      tests++;
      if (host_ready !== (!m_rspv || rsp_ready)) begin
        $display("FAIL R3 model host_ready act=%b exp=%b", host_ready, !m_rspv || rsp_ready); bad = 1;
      end
      if (rsp_valid !== m_rspv) begin
        $display("FAIL R3 model rsp_valid act=%b exp=%b", rsp_valid, m_rspv); bad = 1;
      end else if (m_rspv && rsp_data !== m_rspd) begin
        $display("FAIL R3 model rsp_data act=%h exp=%h", rsp_data, m_rspd); bad = 1;
      end
      for (int i = 0; i < NR; i++)
        if (periph_regs[i*8 +: 8] !== m_regs[i]) begin
          $display("FAIL R4 model reg%0d act=%h exp=%h", i, periph_regs[i*8 +: 8], m_regs[i]); bad = 1;
        end
      if (rx_ready !== 1'b1) begin
        $display("FAIL R9 model rx_ready act=%b exp=1", rx_ready); bad = 1;
      end
      if (bad) fails++;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_valid = 1; host_we = 1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_valid = 0; host_we = 0;
  endtask

  task automatic hr(input logic sel, output logic [7:0] d);
    @(negedge clk);
    host_valid = 1; host_we = 0; host_sel = sel;
    @(negedge clk);
    host_valid = 0;
    #1;
    d = rsp_valid ? rsp_data : 8'hxx;
  endtask

  task automatic shm_wr(input logic [7:0] a, input logic [7:0] d);
    hw(0, a); hw(1, d);
  endtask

  task automatic shm_rd(input logic [7:0] a, output logic [7:0] d);
    hw(0, a); hr(1, d);
  endtask

  task automatic request(input logic [7:0] cmd, input logic [7:0] num, input logic [7:0] val);
    shm_wr(8'h1B, num); shm_wr(8'h1C, val); shm_wr(8'h1A, cmd);
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [7:0] reg_of(input int n);
    return periph_regs[n*8 +: 8];
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 host_ready", {7'd0, host_ready}, 8'd1);
    chk("R1 rsp_valid", {7'd0, rsp_valid}, 8'd0);
    chk("R1 reg0", reg_of(0), 8'h00);
    hr(0, d); chk("R1 pointer", d, 8'h00);
    hr(1, d); chk("R1 byte0", d, 8'h00);

    // R2 pointer
    hw(0, 8'h25); hr(0, d); chk("R2 pointer 0x25", d, 8'h25);
    hw(0, 8'hC7); hr(0, d); chk("R2 pointer masked", d, 8'h07);

    // R3 data location and back-pressure
    shm_wr(8'h05, 8'hA5); shm_rd(8'h05, d); chk("R3 byte5", d, 8'hA5);
    shm_wr(8'h3E, 8'h5C); shm_rd(8'h3E, d); chk("R3 byte3E", d, 8'h5C);
    hw(0, 8'h05);
    @(negedge clk); rsp_ready = 0; host_valid = 1; host_we = 0; host_sel = 1;
    @(negedge clk); host_valid = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R3 held valid", {7'd0, rsp_valid}, 8'd1);
    chk("R3 held data", rsp_data, 8'hA5);
    chk("R3 ready low", {7'd0, host_ready}, 8'd0);
    @(negedge clk); rsp_ready = 1;
    @(negedge clk); #1;
    chk("R3 released", {7'd0, rsp_valid}, 8'd0);

    // R4 write request, incl. last register
    request(8'h01, 8'd3, 8'h5A);
    chk("R4 reg3", reg_of(3), 8'h5A);
    shm_rd(8'h1A, d); chk("R4 ack", d, 8'h00);
    request(8'h01, 8'd15, 8'hE1);
    chk("R4 reg15", reg_of(15), 8'hE1);

    // R5 read request
    request(8'h02, 8'd3, 8'h00);
    shm_rd(8'h1C, d); chk("R5 value", d, 8'h5A);
    shm_rd(8'h1A, d); chk("R5 ack", d, 8'h00);

    // R6 out of range
    request(8'h01, 8'd16, 8'hFF);
    chk("R6 reg0 untouched", reg_of(0), 8'h00);
    shm_rd(8'h1A, d); chk("R6 write acked", d, 8'h00);
    request(8'h02, 8'd40, 8'h99);
    shm_rd(8'h1C, d); chk("R6 read zero", d, 8'h00);

    // R7 unknown command codes
    request(8'h07, 8'd2, 8'h99);
    chk("R7 reg2 untouched", reg_of(2), 8'h00);
    shm_rd(8'h1A, d); chk("R7 cleared", d, 8'h00);
    shm_rd(8'h1C, d); chk("R7 value kept", d, 8'h99);
    request(8'hFF, 8'd1, 8'h44);
    chk("R7 reg1 untouched", reg_of(1), 8'h00);

    // R8 status mirrors
    irq_id = 8'h06; rx_status = 8'h8A;
    shm_rd(8'h1E, d); chk("R8 irq", d, 8'h06);
    shm_rd(8'h1F, d); chk("R8 rx status", d, 8'h8A);

    // R9 receive ring with wrap
    for (int i = 0; i < 33; i++) begin
      @(negedge clk); rx_valid = 1; rx_data = 8'h40 + 8'(i);
    end
    @(negedge clk); rx_valid = 0;
    shm_rd(8'h20, d); chk("R9 slot0 wrapped", d, 8'h60);
    shm_rd(8'h21, d); chk("R9 slot1", d, 8'h41);
    shm_rd(8'h3F, d); chk("R9 slot31", d, 8'h5F);

    // R10 host write collides with the bridge result on 0x1C
    shm_wr(8'h1B, 8'd3);
    hw(0, 8'h1A);
    @(negedge clk); host_valid = 1; host_we = 1; host_sel = 1; host_wdata = 8'h02;
    @(negedge clk); host_sel = 0; host_wdata = 8'h1C;
    @(negedge clk); host_sel = 1; host_wdata = 8'h3C;
    @(negedge clk); host_valid = 0; host_we = 0;
    repeat (6) @(negedge clk);
    shm_rd(8'h1C, d); chk("R10 host wins", d, 8'h3C);
    shm_rd(8'h1A, d); chk("R10 acked", d, 8'h00);

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule